// File: doc/BRIEF.md
# Predictive Segment Sequence Tracker

This block recognises long byte patterns that an upstream detection bank has already split into short segments. Each cycle it receives the index of the segment detected in that cycle, or nothing. It confirms that the segments of a long pattern arrive in the right order and with the right spacing. Each tracker holds a table addressed by segment index. An entry names the segment that must follow, the number of cycles until it is due, and the role the current segment plays in its pattern. When an opening segment appears, the predicted follower is placed into a delay line at the depth that matches the expected spacing. When that prediction reaches the head of the line, it is compared with the segment index presented in that cycle.

Several trackers run side by side on the same index stream. A tracker whose prediction matches can raise a shared link bit. The other trackers then advance as if they had matched too. This lets the tables describe automaton transitions such as a repeated pattern followed by a different one. A completed long pattern is reported as the index of its final segment, one cycle after that segment was presented. The tables are loaded through a simple write port.

Top module: `seqtrk_top`

## Requirements
- R1: After reset every table entry is of kind unused (code 0), every delay line is empty, and `longValid` is low.
- R2: A valid index whose entry has kind head (code 1) schedules that entry's next index. The prediction is compared with the index presented f+1 cycles later, where f is the entry's 4-bit delay field.
- R3: A valid index that meets a matching prediction and whose entry has kind body (code 2) schedules that entry's own next index in the same way.
- R4: A valid index that meets a matching prediction and whose entry has kind tail (code 3) sets `longValid` on the following cycle, with `longIdx` equal to that index.
- R5: A prediction that meets a different index, or no valid index, is discarded. A later correct index then neither advances nor completes the pattern.
- R6: An entry of kind unused never schedules, advances, completes or raises the link bit, even when its index matches a prediction.
- R7: When a tracker's prediction matches and the matched entry has its link bit set, every other tracker treats that cycle's index as matched. Such a tracker schedules the index (body kind) or completes it (tail kind) without a prediction of its own.
- R8: Predictions scheduled in different cycles travel independently, with one in each stage, and can each complete.
- R9: When a new prediction lands in the stage that an older prediction is moving into, the new one replaces the older one.
- R10: In one cycle an index may complete a pattern in one tracker and start a pattern in another, and both effects take place.
- R11: A table write to tracker t at address a takes effect from the next cycle. It changes only that entry of that tracker, and a lookup in the same cycle sees the old content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| curIdx | input | IDX_W | Segment index detected this cycle |
| curValid | input | 1 | `curIdx` holds a detected segment |
| wrEn | input | 1 | Table write strobe |
| wrTrk | input | TRK_W | Tracker whose table is written |
| wrAddr | input | IDX_W | Entry written |
| wrKind | input | 2 | Entry kind: 0 unused, 1 head, 2 body, 3 tail |
| wrNext | input | IDX_W | Index expected next |
| wrDelay | input | DLY_W | Spacing minus one, in cycles |
| wrLink | input | 1 | Raise the shared link bit when this entry matches |
| longIdx | output | IDX_W | Index of the final segment of a detected long pattern |
| longValid | output | 1 | `longIdx` is valid this cycle |

## Verification
Two events can fall in the same cycle: a pattern completing and a new prediction being scheduled. This happens when one index is the tail of a pattern in one tracker and the head of another pattern in a second tracker. It also happens when a fresh prediction is inserted into the stage an older one is shifting into. Directed sequences produce both cases at exact cycle offsets. Long randomised runs over a small index alphabet, with short spacings, produce many more of them. A cycle-level model in the bench, built from the requirements, judges each cycle's output.

// File: rtl/seqtrk_pkg.sv
package seqtrk_pkg;

  typedef enum logic [1:0] {
    SEG_NONE = 2'd0,
    SEG_HEAD = 2'd1,
    SEG_BODY = 2'd2,
    SEG_TAIL = 2'd3
  } seg_kind_e;

  // strobes from control to datapath, one per tracker
  typedef struct packed {
    logic push;
    logic emit;
    logic linkOut;
  } trk_stb_t;

endpackage

// File: rtl/seqtrk_table.sv
module seqtrk_table
  import seqtrk_pkg::*;
#(
  parameter int N_TRK = 2,
  parameter int IDX_W = 6,
  parameter int DLY_W = 4,
  parameter int TRK_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [TRK_W-1:0] wrTrk,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic [1:0]       wrKind,
  input  logic [IDX_W-1:0] wrNext,
  input  logic [DLY_W-1:0] wrDelay,
  input  logic             wrLink,
  input  logic [IDX_W-1:0] rdIdx,
  output seg_kind_e        rdKind  [N_TRK],
  output logic [IDX_W-1:0] rdNext  [N_TRK],
  output logic [DLY_W-1:0] rdDelay [N_TRK],
  output logic             rdLink  [N_TRK]
);

  localparam int ENTRIES = 2 ** IDX_W;

  for (genvar t = 0; t < N_TRK; t++) begin : g_trk
    seg_kind_e        kindMem  [ENTRIES];
    logic [IDX_W-1:0] nextMem  [ENTRIES];
    logic [DLY_W-1:0] delayMem [ENTRIES];
    logic             linkMem  [ENTRIES];
    logic             selThis;

    assign selThis = wrEn && (wrTrk == TRK_W'(t));

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int e = 0; e < ENTRIES; e++) kindMem[e] <= SEG_NONE;
      end else if (selThis) begin
        kindMem[wrAddr] <= seg_kind_e'(wrKind);
      end
    end

    always_ff @(posedge clk) begin
      if (selThis) begin
        nextMem[wrAddr]  <= wrNext;
        delayMem[wrAddr] <= wrDelay;
        linkMem[wrAddr]  <= wrLink;
      end
    end

    assign rdKind[t]  = kindMem[rdIdx];
    assign rdNext[t]  = nextMem[rdIdx];
    assign rdDelay[t] = delayMem[rdIdx];
    assign rdLink[t]  = linkMem[rdIdx];
  end

endmodule

// File: rtl/seqtrk_dpath.sv
module seqtrk_dpath
  import seqtrk_pkg::*;
#(
  parameter int N_TRK = 2,
  parameter int IDX_W = 6,
  parameter int DLY_W = 4,
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [IDX_W-1:0]       curIdx,
  input  logic                   curValid,
  input  trk_stb_t               stb       [N_TRK],
  input  logic [IDX_W-1:0]       pushNext  [N_TRK],
  input  logic [DLY_W-1:0]       pushDelay [N_TRK],
  output logic                   headHit   [N_TRK],
  output logic [N_TRK*DEPTH-1:0] occVec
);

  for (genvar t = 0; t < N_TRK; t++) begin : g_line
    logic [DEPTH-1:0] vldQ, vldD;
    logic [IDX_W-1:0] idxQ [DEPTH];
    logic [IDX_W-1:0] idxD [DEPTH];

    // shift toward stage 0, then let a new prediction claim its stage
    always_comb begin
      for (int s = 0; s < DEPTH - 1; s++) begin
        vldD[s] = vldQ[s+1];
        idxD[s] = idxQ[s+1];
      end
      vldD[DEPTH-1] = 1'b0;
      idxD[DEPTH-1] = '0;
      if (stb[t].push) begin
        vldD[pushDelay[t]] = 1'b1;
        idxD[pushDelay[t]] = pushNext[t];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) vldQ <= '0;
      else     vldQ <= vldD;
    end

    always_ff @(posedge clk) begin
      for (int s = 0; s < DEPTH; s++) idxQ[s] <= idxD[s];
    end

    assign headHit[t] = curValid && vldQ[0] && (idxQ[0] == curIdx);
    assign occVec[t*DEPTH +: DEPTH] = vldQ;
  end

endmodule

// File: rtl/seqtrk_ctrl.sv
module seqtrk_ctrl
  import seqtrk_pkg::*;
#(
  parameter int N_TRK = 2,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] curIdx,
  input  logic             curValid,
  input  seg_kind_e        rdKind  [N_TRK],
  input  logic             rdLink  [N_TRK],
  input  logic             headHit [N_TRK],
  output trk_stb_t         stb     [N_TRK],
  output logic [IDX_W-1:0] longIdx,
  output logic             longValid
);

  logic [N_TRK-1:0] linkBus;
  logic [N_TRK-1:0] emitVec;

  for (genvar t = 0; t < N_TRK; t++) begin : g_lnk
    assign linkBus[t] = headHit[t] && rdLink[t] && (rdKind[t] != SEG_NONE);
  end

  for (genvar t = 0; t < N_TRK; t++) begin : g_dec
    logic [N_TRK-1:0] others;
    logic             linkIn;
    logic             advance;

    always_comb begin
      others    = linkBus;
      others[t] = 1'b0;
    end

    assign linkIn  = |others;
    assign advance = curValid && (headHit[t] || linkIn);

    assign stb[t].push    = curValid && ((rdKind[t] == SEG_HEAD) ||
                                         ((rdKind[t] == SEG_BODY) && advance));
    assign stb[t].emit    = advance && (rdKind[t] == SEG_TAIL);
    assign stb[t].linkOut = linkBus[t];
    assign emitVec[t]     = stb[t].emit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      longValid <= 1'b0;
      longIdx   <= '0;
    end else begin
      longValid <= |emitVec;
      if (|emitVec) longIdx <= curIdx;
    end
  end

endmodule

// File: rtl/seqtrk_top.sv
module seqtrk_top
  import seqtrk_pkg::*;
#(
  parameter int N_TRK = 2,
  parameter int IDX_W = 6,
  parameter int DLY_W = 4,
  localparam int DEPTH = 2 ** DLY_W,
  localparam int TRK_W = (N_TRK > 1) ? $clog2(N_TRK) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] curIdx,
  input  logic             curValid,
  input  logic             wrEn,
  input  logic [TRK_W-1:0] wrTrk,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic [1:0]       wrKind,
  input  logic [IDX_W-1:0] wrNext,
  input  logic [DLY_W-1:0] wrDelay,
  input  logic             wrLink,
  output logic [IDX_W-1:0] longIdx,
  output logic             longValid
);

  seg_kind_e        rdKind  [N_TRK];
  logic [IDX_W-1:0] rdNext  [N_TRK];
  logic [DLY_W-1:0] rdDelay [N_TRK];
  logic             rdLink  [N_TRK];
  logic             headHit [N_TRK];
  trk_stb_t         stb     [N_TRK];
  logic [N_TRK*DEPTH-1:0] occVec;
  logic [N_TRK-1:0] pushVec;
  logic [N_TRK-1:0] tailVec;

  seqtrk_table #(
    .N_TRK(N_TRK), .IDX_W(IDX_W), .DLY_W(DLY_W), .TRK_W(TRK_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .wrEn(wrEn), .wrTrk(wrTrk), .wrAddr(wrAddr), .wrKind(wrKind),
    .wrNext(wrNext), .wrDelay(wrDelay), .wrLink(wrLink),
    .rdIdx(curIdx),
    .rdKind(rdKind), .rdNext(rdNext), .rdDelay(rdDelay), .rdLink(rdLink)
  );

  seqtrk_dpath #(
    .N_TRK(N_TRK), .IDX_W(IDX_W), .DLY_W(DLY_W), .DEPTH(DEPTH)
  ) u_dpath (
    .clk(clk), .rst(rst),
    .curIdx(curIdx), .curValid(curValid),
    .stb(stb), .pushNext(rdNext), .pushDelay(rdDelay),
    .headHit(headHit), .occVec(occVec)
  );

  seqtrk_ctrl #(
    .N_TRK(N_TRK), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .curIdx(curIdx), .curValid(curValid),
    .rdKind(rdKind), .rdLink(rdLink), .headHit(headHit),
    .stb(stb), .longIdx(longIdx), .longValid(longValid)
  );

  for (genvar t = 0; t < N_TRK; t++) begin : g_obs
    assign pushVec[t] = stb[t].push;
    assign tailVec[t] = (rdKind[t] == SEG_TAIL);
  end

endmodule

// File: rtl/seqtrk_chk.sv
module seqtrk_chk #(
  parameter int N_TRK = 2,
  parameter int IDX_W = 6,
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic [IDX_W-1:0]       curIdx,
  input logic                   curValid,
  input logic [IDX_W-1:0]       longIdx,
  input logic                   longValid,
  input logic [N_TRK-1:0]       pushVec,
  input logic [N_TRK-1:0]       tailVec,
  input logic [N_TRK*DEPTH-1:0] occVec
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !longValid);

  // R4
  emit_from_tail_chk: assert property (@(posedge clk) disable iff (rst)
    longValid |-> ($past(curValid) && $past(|tailVec) && longIdx == $past(curIdx)));

  // R2
  push_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
    (|pushVec) |-> curValid);

  for (genvar t = 0; t < N_TRK; t++) begin : g_occ
    // R8
    occ_growth_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(occVec[t*DEPTH +: DEPTH]) <= $past($countones(occVec[t*DEPTH +: DEPTH])) + 1);
  end

endmodule

bind seqtrk_top seqtrk_chk #(
  .N_TRK(N_TRK), .IDX_W(IDX_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .curIdx(curIdx), .curValid(curValid),
  .longIdx(longIdx), .longValid(longValid),
  .pushVec(pushVec), .tailVec(tailVec), .occVec(occVec)
);

// File: tb/tb_seqtrk_top.sv
`timescale 1ns/100ps
module tb_seqtrk_top;
  localparam int N = 2;
  localparam int IW = 6;
  localparam int DW = 4;
  localparam int DP = 16;
  localparam int EN = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IW-1:0] curIdx = '0;
  logic curValid = 1'b0;
  logic wrEn = 1'b0;
  logic [0:0] wrTrk = '0;
  logic [IW-1:0] wrAddr = '0;
  logic [1:0] wrKind = '0;
  logic [IW-1:0] wrNext = '0;
  logic [DW-1:0] wrDelay = '0;
  logic wrLink = 1'b0;
  logic [IW-1:0] longIdx;
  logic longValid;

  always #2.5 clk = ~clk;

  seqtrk_top #(.N_TRK(N), .IDX_W(IW), .DLY_W(DW)) dut (
    .clk(clk), .rst(rst), .curIdx(curIdx), .curValid(curValid),
    .wrEn(wrEn), .wrTrk(wrTrk), .wrAddr(wrAddr), .wrKind(wrKind),
    .wrNext(wrNext), .wrDelay(wrDelay), .wrLink(wrLink),
    .longIdx(longIdx), .longValid(longValid)
  );

  // reference state
  int mKind [N][EN];
  int mNext [N][EN];
  int mDly  [N][EN];
  bit mLink [N][EN];
  bit mV    [N][DP];
  int mI    [N][DP];
  bit expValid;
  int expIdx;
  int vectors = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R1";

  task automatic model_reset();
    for (int t = 0; t < N; t++) begin
      for (int e = 0; e < EN; e++) begin
        mKind[t][e] = 0; mNext[t][e] = 0; mDly[t][e] = 0; mLink[t][e] = 0;
      end
      for (int s = 0; s < DP; s++) begin mV[t][s] = 0; mI[t][s] = 0; end
    end
    expValid = 0;
  endtask

  function automatic bit lnk_of(int t, int idx, bit v);
    bit hit = v && mV[t][0] && (mI[t][0] == idx);
    return hit && mLink[t][idx] && (mKind[t][idx] != 0);
  endfunction

  // one cycle: optional index, optional write
  task automatic cyc(int idx, bit v, bit we = 0, int wt = 0, int wa = 0,
                     int wk = 0, int wn = 0, int wd = 0, bit wl = 0);
    bit lo [N];
    bit anyEmit = 0;
    @(negedge clk);
    curIdx = IW'(idx); curValid = v;
    wrEn = we; wrTrk = 1'(wt); wrAddr = IW'(wa); wrKind = 2'(wk);
    wrNext = IW'(wn); wrDelay = DW'(wd); wrLink = wl;
    for (int t = 0; t < N; t++) lo[t] = lnk_of(t, idx, v);
    for (int t = 0; t < N; t++) begin
      bit hit = v && mV[t][0] && (mI[t][0] == idx);
      bit lin = 0;
      bit adv;
      bit psh;
      for (int u = 0; u < N; u++) if (u != t && lo[u]) lin = 1;
      adv = v && (hit || lin);
      psh = v && (mKind[t][idx] == 1 || (mKind[t][idx] == 2 && adv));
      if (adv && mKind[t][idx] == 3) anyEmit = 1;
      for (int s = 0; s < DP - 1; s++) begin mV[t][s] = mV[t][s+1]; mI[t][s] = mI[t][s+1]; end
      mV[t][DP-1] = 0;
      if (psh) begin mV[t][mDly[t][idx]] = 1; mI[t][mDly[t][idx]] = mNext[t][idx]; end
    end
    expValid = anyEmit;
    if (anyEmit) expIdx = idx;
    if (we) begin
      mKind[wt][wa] = wk; mNext[wt][wa] = wn; mDly[wt][wa] = wd; mLink[wt][wa] = wl;
    end
    @(posedge clk);
    #1;
    vectors++;
    if (longValid !== expValid || (expValid && longIdx !== IW'(expIdx))) begin
      fails++;
      $display("FAIL %s: longValid=%0b longIdx=%0d expected longValid=%0b longIdx=%0d",
               tag, longValid, longIdx, expValid, expIdx);
    end
  endtask

  task automatic wr(int t, int a, int k, int n, int d, bit l);
    cyc(0, 0, 1, t, a, k, n, d, l);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: empty tables, any input gives nothing
    tag = "R1";
    for (int i = 0; i < 6; i++) cyc(i * 7, 1);

    // pattern: 5 -(3)-> 9 -(1)-> 12 tail
    wr(0, 5, 1, 9, 2, 0);
    wr(0, 9, 2, 12, 0, 0);
    wr(0, 12, 3, 0, 0, 0);
    idle(2);

    tag = "R2 R3 R4";
    cyc(5, 1); cyc(0, 1); cyc(0, 1); cyc(9, 1); cyc(12, 1); cyc(0, 0);

    tag = "R5";
    cyc(5, 1); cyc(0, 1); cyc(0, 1); cyc(0, 1); cyc(9, 1); cyc(12, 1); cyc(0, 0);
    cyc(5, 1); cyc(0, 1); cyc(0, 0); cyc(9, 1); cyc(12, 1); cyc(0, 0);
    cyc(5, 1); cyc(0, 1); cyc(0, 1); cyc(9, 1); cyc(13, 1); cyc(0, 0);

    tag = "R6";
    wr(0, 9, 0, 12, 0, 0);
    cyc(5, 1); cyc(0, 1); cyc(0, 1); cyc(9, 1); cyc(12, 1); cyc(0, 0);
    wr(0, 9, 2, 12, 0, 1);

    // R7: tracker 1 completes on 9 only through the link bit
    tag = "R7";
    wr(1, 9, 3, 0, 0, 0);
    cyc(5, 1); cyc(0, 1); cyc(0, 1); cyc(9, 1); cyc(0, 0);
    wr(0, 9, 2, 12, 0, 0);
    cyc(5, 1); cyc(0, 1); cyc(0, 1); cyc(9, 1); cyc(0, 0);
    wr(1, 9, 0, 0, 0, 0);

    // R8: two predictions in flight
    tag = "R8";
    wr(0, 20, 1, 21, 3, 0);
    wr(0, 21, 3, 0, 0, 0);
    cyc(5, 1); cyc(20, 1); cyc(0, 1); cyc(9, 1); cyc(12, 1); cyc(21, 1); cyc(0, 0);

    // R9: newer prediction claims the stage
    tag = "R9";
    wr(0, 30, 1, 31, 3, 0);
    wr(0, 31, 3, 0, 0, 0);
    wr(0, 40, 1, 41, 2, 0);
    wr(0, 41, 3, 0, 0, 0);
    cyc(30, 1); cyc(40, 1); cyc(0, 1); cyc(0, 1); cyc(31, 1); cyc(0, 0);
    cyc(30, 1); cyc(40, 1); cyc(0, 1); cyc(0, 1); cyc(41, 1); cyc(0, 0);

    // R10: 12 completes in tracker 0 and starts in tracker 1
    tag = "R10";
    wr(1, 12, 1, 13, 0, 0);
    wr(1, 13, 3, 0, 0, 0);
    cyc(5, 1); cyc(0, 1); cyc(0, 1); cyc(9, 1); cyc(12, 1); cyc(13, 1); cyc(0, 0);

    // R11: write in the cycle of lookup sees old entry; other tracker untouched
    tag = "R11";
    wr(0, 51, 3, 0, 0, 0);
    cyc(50, 1, 1, 0, 50, 1, 51, 0, 0);
    cyc(51, 1); cyc(0, 0);
    cyc(50, 1); cyc(51, 1); cyc(0, 0);
    cyc(50, 1, 1, 1, 51, 0, 0, 0, 0);
    cyc(51, 1); cyc(0, 0);

    // random phase over a small alphabet
    tag = "R8 random";
    for (int r = 0; r < 40; r++)
      wr($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 3),
         $urandom_range(0, 7), $urandom_range(0, 3), 1'($urandom_range(0, 1)));
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 49) == 0)
        cyc($urandom_range(0, 7), 1'($urandom_range(0, 1)), 1,
            $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 3),
            $urandom_range(0, 7), $urandom_range(0, 3), 1'($urandom_range(0, 1)));
      else
        cyc($urandom_range(0, 7), $urandom_range(0, 9) != 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule